// File: doc/BRIEF.md
# Square-Root Carry-Select Adder

This block adds two 20-bit unsigned operands and a carry-in. The result is a 20-bit sum and a carry-out. It is purely combinational: a change on any input reaches the outputs without a clock.

The operand bits are split into five blocks of increasing width: 2, 3, 4, 5 and 6 bits. The lowest block is a plain ripple chain fed by the external carry-in.

Every higher block works ahead of time. It forms per-bit propagate (A XOR B) and generate (A AND B). It then runs two ripple chains side by side, one that assumes an incoming carry of 0 and one that assumes 1. When the real carry arrives from the block below, it only has to steer a multiplexer. That multiplexer picks both the block's carry-out and its internal carry vector. Each sum bit is then the propagate bit XOR the selected carry into that position.

Each block is one bit wider than the one before it. This gives a longer block more time to finish its chains while the selecting carry works its way up. The worst-case delay therefore grows with the square root of the width rather than linearly.

Top module: `sqrt_csel_adder`

## Requirements
- R1: `sum_out` equals the low 20 bits of `op_a + op_b + carry_in`, for any operand values.
- R2: `carry_out` equals bit 20 of the 21-bit value `op_a + op_b + carry_in`.
- R3: The block boundaries sit at bit positions 2, 5, 9 and 14. The carry entering each boundary equals bit `lo` of the sum of the operands' bits below `lo`, plus `carry_in`.
- R4: The lowest block (bits 0 and 1) ripples directly from `carry_in`. With both operands zero, `sum_out` equals `carry_in` (bit 0) and `carry_out` is 0.
- R5: Every block above the lowest precomputes two carry-outs: one for an assumed carry-in of 0 and one for an assumed carry-in of 1. The first is never 1 while the second is 0.
- R6: When every bit of a higher block propagates (A XOR B all ones over the block), its precomputed carry-outs are 0 and 1, so the block passes the incoming carry through. Otherwise the two are equal and do not depend on the incoming carry.
- R7: All-ones plus zero with `carry_in` = 1 wraps `sum_out` to zero and sets `carry_out` to 1. A carry then travels through every block.
- R8: Operands whose bit pairs all generate, or all kill, give carries that do not depend on `carry_in` above bit 0.
- R9: The outputs follow the inputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 20 | First addend |
| op_b | input | 20 | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 20 | Low 20 bits of the total |
| carry_out | output | 1 | Carry out of bit 19 |

## Verification
The assertions are evaluated combinationally. They assume the three inputs are free of unknown values and change together as one vector. They skip any evaluation in which an input is still unknown.

The stimulus drives all three inputs in a single step, one clock phase away from the sampling point. It never leaves any of them undriven once reset has been released.

The boundary-carry and precomputed-carry checks depend on the internal block boundaries. The directed vectors are therefore chosen so that each boundary sees a carry arrive, a carry be killed, and a full propagate run.

// File: rtl/csa_pkg.sv
// Package: shared helpers for the carry-select adder.
// Block k (counting from 0) is FIRST_W + k bits wide.
// Its lowest bit sits at k*FIRST_W + k*(k-1)/2.
package csa_pkg;

    // Lowest bit position of block k.
    function automatic int blk_lo(input int first_w, input int k);
        return k * first_w + (k * (k - 1)) / 2;
    endfunction

    // Width of block k.
    function automatic int blk_w(input int first_w, input int k);
        return first_w + k;
    endfunction

    // Total operand width for nblk blocks.
    function automatic int total_w(input int first_w, input int nblk);
        return nblk * first_w + (nblk * (nblk - 1)) / 2;
    endfunction

endpackage

// File: rtl/csa_setup.sv
// Setup stage: forms per-bit propagate (XOR) and generate (AND).
// Assumes nothing beyond matching operand widths.
module csa_setup #(
    parameter int BW = 4
) (
    input  logic [BW-1:0] a,
    input  logic [BW-1:0] b,
    output logic [BW-1:0] p,
    output logic [BW-1:0] g
);
    // Bitwise propagate and generate.
    always_comb begin
        p = a ^ b;
        g = a & b;
    end
endmodule

// File: rtl/csa_ripple.sv
// Ripple carry chain over BW positions.
// cvec[i] is the carry entering position i; cout leaves the top position.
// Assumes p and g come from the setup stage.
module csa_ripple #(
    parameter int BW = 4
) (
    input  logic [BW-1:0] p,
    input  logic [BW-1:0] g,
    input  logic          cin,
    output logic [BW-1:0] cvec,
    output logic          cout
);
    logic run;

    // Walk the carry upward, one position at a time.
    always_comb begin
        run = cin;
        for (int i = 0; i < BW; i++) begin
            cvec[i] = run;
            run     = g[i] | (p[i] & run);
        end
        cout = run;
    end
endmodule

// File: rtl/csa_plain_block.sv
// Lowest block: a single ripple chain driven by the external carry-in.
// There is no duplicated chain here, since the real carry is known at once.
module csa_plain_block #(
    parameter int BW = 2
) (
    input  logic [BW-1:0] a,
    input  logic [BW-1:0] b,
    input  logic          cin,
    output logic [BW-1:0] sum,
    output logic          cout
);
    logic [BW-1:0] p, g, cvec;

    csa_setup #(.BW(BW)) u_setup (.a(a), .b(b), .p(p), .g(g));
    csa_ripple #(.BW(BW)) u_chain (.p(p), .g(g), .cin(cin), .cvec(cvec), .cout(cout));

    // Sum bit: propagate XOR the carry entering the position.
    always_comb sum = p ^ cvec;
endmodule

// File: rtl/csa_select_block.sv
// Carry-select block: two chains assume carry-in 0 and carry-in 1.
// The real carry from below then picks both the carry vector and the carry-out.
// Assumes cin_sel settles no earlier than the two chains (balanced sizing).
module csa_select_block #(
    parameter int BW = 3
) (
    input  logic [BW-1:0] a,
    input  logic [BW-1:0] b,
    input  logic          cin_sel,
    output logic [BW-1:0] sum,
    output logic          cout,
    output logic          pre_c0,
    output logic          pre_c1
);
    logic [BW-1:0] p, g;
    logic [BW-1:0] cvec0, cvec1, cvec_sel;

    csa_setup #(.BW(BW)) u_setup (.a(a), .b(b), .p(p), .g(g));
    csa_ripple #(.BW(BW)) u_chain0 (.p(p), .g(g), .cin(1'b0), .cvec(cvec0), .cout(pre_c0));
    csa_ripple #(.BW(BW)) u_chain1 (.p(p), .g(g), .cin(1'b1), .cvec(cvec1), .cout(pre_c1));

    // Multiplexer: the arriving carry picks the matching precomputed result.
    always_comb begin
        cvec_sel = cin_sel ? cvec1  : cvec0;
        cout     = cin_sel ? pre_c1 : pre_c0;
    end

    // Sum formation after selection.
    always_comb sum = p ^ cvec_sel;
endmodule

// File: rtl/sqrt_csel_adder.sv
// Top: square-root carry-select adder.
// NUM_BLK blocks are laid out with widths FIRST_W, FIRST_W+1, ...
// The total width is derived from these two parameters (20 by default).
// Purely combinational; the caller registers the result if it needs to.
module sqrt_csel_adder #(
    parameter int FIRST_W = 2,
    parameter int NUM_BLK = 5,
    parameter int W       = csa_pkg::total_w(FIRST_W, NUM_BLK)
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         carry_in,
    output logic [W-1:0] sum_out,
    output logic         carry_out
);
    // Carry entering each block; the top entry leaves the adder.
    logic [NUM_BLK:0]   bnd_carry;
    // Precomputed carry-outs; entry 0 mirrors the plain block's carry-out.
    logic [NUM_BLK-1:0] pre_c0;
    logic [NUM_BLK-1:0] pre_c1;

    // Seed the boundary chain with the external carry.
    always_comb bnd_carry[0] = carry_in;

    for (genvar k = 0; k < NUM_BLK; k++) begin : g_blk
        localparam int LO = csa_pkg::blk_lo(FIRST_W, k);
        localparam int BW = csa_pkg::blk_w(FIRST_W, k);
        if (k == 0) begin : g_plain
            csa_plain_block #(.BW(BW)) u_blk (
                .a    (op_a[LO +: BW]),
                .b    (op_b[LO +: BW]),
                .cin  (bnd_carry[k]),
                .sum  (sum_out[LO +: BW]),
                .cout (bnd_carry[k+1])
            );
            // No duplicated chain in the lowest block.
            always_comb begin
                pre_c0[k] = bnd_carry[k+1];
                pre_c1[k] = bnd_carry[k+1];
            end
        end else begin : g_sel
            csa_select_block #(.BW(BW)) u_blk (
                .a       (op_a[LO +: BW]),
                .b       (op_b[LO +: BW]),
                .cin_sel (bnd_carry[k]),
                .sum     (sum_out[LO +: BW]),
                .cout    (bnd_carry[k+1]),
                .pre_c0  (pre_c0[k]),
                .pre_c1  (pre_c1[k])
            );
        end
    end

    // The adder's carry-out is the last block's selected carry.
    always_comb carry_out = bnd_carry[NUM_BLK];
endmodule

// File: rtl/csa_checker.sv
// Checker for the carry-select adder.
// Uses immediate assertions, since the block has no clock.
// Assumes the inputs change together; evaluations with unknown inputs are skipped.
module csa_checker #(
    parameter int FIRST_W = 2,
    parameter int NUM_BLK = 5,
    parameter int W       = 20
) (
    input logic [W-1:0]       op_a,
    input logic [W-1:0]       op_b,
    input logic               carry_in,
    input logic [W-1:0]       sum_out,
    input logic               carry_out,
    input logic [NUM_BLK:0]   bnd_carry,
    input logic [NUM_BLK-1:0] pre_c0,
    input logic [NUM_BLK-1:0] pre_c1
);
    logic known;
    logic [W:0] full;

    // Arithmetic reference for the whole adder (R1, R2).
    always_comb begin
        known = !$isunknown({op_a, op_b, carry_in});
        full  = {1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, carry_in};
        if (known) begin
            a_r1_sum_value:  assert (sum_out == full[W-1:0]);
            a_r2_carry_out:  assert (carry_out == full[W]);
        end
    end

    for (genvar k = 1; k < NUM_BLK; k++) begin : g_chk
        localparam int LO = csa_pkg::blk_lo(FIRST_W, k);
        localparam int BW = csa_pkg::blk_w(FIRST_W, k);
        logic [W:0] low_sum;
        logic       all_prop;

        // Boundary carry and precomputed-carry relations for block k.
        always_comb begin
            low_sum  = {1'b0, op_a & ((W)'(1) << LO) - (W)'(1)}
                     + {1'b0, op_b & ((W)'(1) << LO) - (W)'(1)}
                     + {{W{1'b0}}, carry_in};
            all_prop = &(op_a[LO +: BW] ^ op_b[LO +: BW]);
            if (known) begin
                a_r3_boundary_carry: assert (bnd_carry[k] == low_sum[LO]);
                a_r5_carry_order:    assert (!(pre_c0[k] && !pre_c1[k]));
                a_r6_pass_through:   assert (all_prop == (pre_c0[k] != pre_c1[k]));
            end
        end
    end
endmodule

bind sqrt_csel_adder csa_checker #(
    .FIRST_W (FIRST_W),
    .NUM_BLK (NUM_BLK),
    .W       (W)
) u_csa_checker (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .sum_out   (sum_out),
    .carry_out (carry_out),
    .bnd_carry (bnd_carry),
    .pre_c0    (pre_c0),
    .pre_c1    (pre_c1)
);

// File: tb/tb_sqrt_csel_adder.sv
module tb_sqrt_csel_adder;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 20;
    localparam int N_RAND     = 3000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         carry_in = 1'b0;
    logic [W-1:0] sum_out;
    logic         carry_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // Expected results, one per applied vector, consumed in order.
    logic [W:0] exp_q[$];

    sqrt_csel_adder dut (
        .op_a      (op_a),
        .op_b      (op_b),
        .carry_in  (carry_in),
        .sum_out   (sum_out),
        .carry_out (carry_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference.
    function automatic logic [W:0] model(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
        longint unsigned t;
        t = longint'(a) + longint'(b) + longint'(c);
        return t[W:0];
    endfunction

    task automatic compare(input string tag);
        logic [W:0] exp;
        exp = exp_q.pop_front();
        n_cmp++;
        if ({carry_out, sum_out} !== exp) begin
            n_bad++;
            $display("FAIL %s: got carry=%0b sum=%h, expected carry=%0b sum=%h",
                     tag, carry_out, sum_out, exp[W], exp[W-1:0]);
        end
    endtask

    // Drive on the rising edge, compare at the falling edge.
    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic c, input string tag);
        @(posedge clk);
        op_a = a; op_b = b; carry_in = c;
        exp_q.push_back(model(a, b, c));
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        logic [W-1:0] ones;
        int bnd[4];
        ones = '1;
        bnd[0] = 2; bnd[1] = 5; bnd[2] = 9; bnd[3] = 14;
        repeat (3) @(posedge clk);
        // Reset state: zero inputs give zero outputs.
        @(negedge clk);
        exp_q.push_back('0);
        compare("R1 reset state zero");
        rst_n = 1'b1;

        apply('0, '0, 1'b0, "R4 zero plus zero");
        apply('0, '0, 1'b1, "R4 carry-in lands in bit 0");
        apply(ones, '0, 1'b1, "R7 all-ones plus carry wraps");
        apply(ones, 20'h00001, 1'b0, "R7 all-ones plus one");
        apply(ones, ones, 1'b1, "R2 max operands with carry");
        apply(20'hAAAAA, 20'h55555, 1'b0, "R6 alternating full propagate cin0");
        apply(20'hAAAAA, 20'h55555, 1'b1, "R6 alternating full propagate cin1");
        apply(20'hAAAAA, 20'hAAAAA, 1'b0, "R1 alternating doubled");
        apply(ones, ones, 1'b0, "R8 all generate cin0");
        apply(ones, ones, 1'b1, "R8 all generate cin1");
        apply('0, '0, 1'b1, "R8 all kill cin1");

        // Carry arriving exactly at each block boundary.
        foreach (bnd[i]) begin
            logic [W-1:0] m;
            m = (20'h1 << bnd[i]) - 20'h1;
            apply(m, '0, 1'b1, $sformatf("R3 ripple to boundary %0d", bnd[i]));
            apply(m, m, 1'b0, $sformatf("R3 generate into boundary %0d", bnd[i]));
            apply(m, ~m, 1'b1, $sformatf("R5 propagate above boundary %0d", bnd[i]));
            apply(m << 1, '0, 1'b0, $sformatf("R3 no carry at boundary %0d", bnd[i]));
        end

        // Outputs follow inputs between clock edges.
        @(negedge clk);
        op_a = 20'h12345; op_b = 20'h0FEDC; carry_in = 1'b1;
        exp_q.push_back(model(20'h12345, 20'h0FEDC, 1'b1));
        #1;
        compare("R9 combinational response without clock");

        for (int i = 0; i < N_RAND; i++) begin
            apply(W'($urandom), W'($urandom), 1'($urandom), "R1 R2 random vector");
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule